// File: doc/BRIEF.md
# Synchronous Asynchronous-SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. A requester presents one request at a time on a valid/ready handshake: a write/read select, a word address, write data and a per-lane enable mask. The controller then drives the memory's active-low chip enable, write enable, output enable and lane strobes, the address, and the write data with a separate drive enable. Reads come back as data with a one-cycle valid pulse.

All strobe timing comes from counters. Each phase length is the memory's nanosecond minimum divided by the clock period, rounded up, with a floor of one cycle. Changing the clock-period parameter re-derives every count. Writes keep the output enable high throughout. Write data is driven only from the second cycle of the write-enable pulse. After any read, a recovery phase lets the memory's outputs reach high impedance before the controller may drive the bus again.

Top module: `sram_ctl`

## Requirements
- R1: Phase lengths equal ceil(ns / CLK_NS), at least 1. At the default 5 ns clock the write-enable low pulse lasts exactly 8 cycles.
- R2: In the cycle after a write is accepted, the address, chip enable (low) and the lane strobes are applied with write enable still high. Strobe bit 0 serves dq[7:0] and bit 1 serves dq[15:8]; mask bit 1 means the lane is enabled and drives its strobe low. Write enable falls one cycle later.
- R3: Output enable stays high for the whole write. Data drive starts one cycle after write enable falls, stops when write enable rises, and lasts at least 25 ns (5 cycles) before that rise.
- R4: A write occupies 11 cycles from acceptance before ready is high again, which meets the 55 ns write cycle.
- R5: A read applies address, chip enable, output enable and lane strobes for 11 cycles. Data is sampled at the end of the last of them, and rsp_valid is high in the 11th cycle after the accepting edge.
- R6: A lane whose mask bit is 0 reads back as zero.
- R7: After a read, all strobes rise together, ready stays low for a further 4 cycles (20 ns), and data drive never starts within 20 ns of output enable rising.
- R8: A request with mask 00 is a no-op. Chip enable stays high and ready stays high. A no-op read returns rsp_valid with zero data in the cycle right after acceptance, and a no-op write changes no memory word.
- R9: req_ready is low from acceptance until the sequence ends, and in every cycle where chip enable is low.
- R10: During and after reset, ready is high, rsp_valid is low, all strobes are high and data drive is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 8*LANES | Write data |
| req_be | input | LANES | Lane enable mask, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8*LANES | Read data, disabled lanes zero |
| sram_addr | output | AW | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | LANES | Lane strobes, active low |
| sram_dq_out | output | 8*LANES | Data toward memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 8*LANES | Data from memory |

## Verification
The bus turnaround is the point where two functions can fall in the same cycle. The read's release of the output enable and its recovery overlap the start of the next write's data drive if the recovery count is short. The bench provokes this by issuing a write as soon as ready returns after a read. A memory model tracks cycles since output enable rose and reports any drive inside the 20 ns window. The same model returns filler bytes until the address has been stable for 55 ns, so a read that samples early or late is caught by the scoreboard on both data and arrival cycle.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WADDR,
    S_WPULSE,
    S_WTAIL,
    S_RACC,
    S_RHZ
  } state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int CW     = 4,
  parameter int N_WE   = 8,
  parameter int N_TAIL = 2,
  parameter int N_RD   = 11,
  parameter int N_HZ   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             accept,
  output logic             noop_rd,
  output logic             cap,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CW-1:0]    cnt_val,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] be_n,
  output logic             dq_oe
);

  localparam logic [CW-1:0] L_ADDR = '0;
  localparam logic [CW-1:0] L_WE   = CW'(N_WE - 1);
  localparam logic [CW-1:0] L_TAIL = CW'(N_TAIL - 1);
  localparam logic [CW-1:0] L_RD   = CW'(N_RD - 1);
  localparam logic [CW-1:0] L_HZ   = CW'(N_HZ - 1);

  state_e           state_q, state_d;
  logic             ce_d, we_d, oe_d, drv_d;
  logic [LANES-1:0] be_d;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign noop_rd   = accept && (req_be == '0) && !req_write;
  assign cap       = (state_q == S_RACC) && cnt_zero;

  always_comb begin
    state_d  = state_q;
    ce_d     = ce_n;
    we_d     = we_n;
    oe_d     = oe_n;
    be_d     = be_n;
    drv_d    = dq_oe;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid && (req_be != '0)) begin
          ce_d     = 1'b0;
          be_d     = ~req_be;
          cnt_load = 1'b1;
          if (req_write) begin
            state_d = S_WADDR;
            cnt_val = L_ADDR;
          end else begin
            state_d = S_RACC;
            oe_d    = 1'b0;
            cnt_val = L_RD;
          end
        end
      end
      S_WADDR: begin
        if (cnt_zero) begin
          state_d  = S_WPULSE;
          we_d     = 1'b0;
          cnt_load = 1'b1;
          cnt_val  = L_WE;
        end
      end
      S_WPULSE: begin
        if (cnt_zero) begin
          state_d  = S_WTAIL;
          we_d     = 1'b1;
          drv_d    = 1'b0;
          ce_d     = 1'b1;
          be_d     = '1;
          cnt_load = 1'b1;
          cnt_val  = L_TAIL;
        end else begin
          drv_d = 1'b1;
        end
      end
      S_WTAIL: begin
        if (cnt_zero) state_d = S_IDLE;
      end
      S_RACC: begin
        if (cnt_zero) begin
          state_d  = S_RHZ;
          ce_d     = 1'b1;
          oe_d     = 1'b1;
          be_d     = '1;
          cnt_load = 1'b1;
          cnt_val  = L_HZ;
        end
      end
      S_RHZ: begin
        if (cnt_zero) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      be_n    <= '1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_d;
      we_n    <= we_d;
      oe_n    <= oe_d;
      be_n    <= be_d;
      dq_oe   <= drv_d;
    end
  end

  // Checker counters: length of the current write-enable pulse and time since output enable rose
  localparam int GW = CW + 1;
  logic [GW-1:0] we_low_cnt, hz_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      hz_gap     <= '1;
    end else begin
      if (!we_n) begin
        if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
      end else begin
        we_low_cnt <= '0;
      end
      if (!oe_n)            hz_gap <= '0;
      else if (hz_gap != '1) hz_gap <= hz_gap + 1'b1;
    end
  end

  p_we_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (int'(we_low_cnt) >= N_WE));

  p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_drive_inside_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  p_drive_after_we_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!we_n));

  p_hz_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (int'(hz_gap) >= N_HZ));

  p_noop_no_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_be == '0)) |=> ce_n);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int AW    = 16,
  parameter int LANES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap,
  input  logic              noop_rd,
  input  logic [AW-1:0]     req_addr,
  input  logic [8*LANES-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [8*LANES-1:0] sram_dq_in,
  output logic [AW-1:0]     addr_q,
  output logic [8*LANES-1:0] wdata_q,
  output logic              rsp_valid,
  output logic [8*LANES-1:0] rsp_rdata
);

  localparam int DW = 8 * LANES;

  logic [LANES-1:0] be_q;
  logic [DW-1:0]    lane_mask;
  logic [DW-1:0]    rdata_d;
  logic             rdata_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*8 +: 8] = {8{be_q[l]}};
  end

  always_comb begin
    rdata_en = cap || noop_rd;
    rdata_d  = cap ? (sram_dq_in & lane_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rdata_en;
      if (rdata_en) rsp_rdata <= rdata_d;
    end
  end

  p_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~lane_mask) == '0));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 16,
  parameter int LANES   = 2,
  parameter int CLK_NS  = 5,
  parameter int T_WC    = 55,
  parameter int T_PWE   = 40,
  parameter int T_AW    = 40,
  parameter int T_SLEAD = 40,
  parameter int T_SD    = 25,
  parameter int T_RC    = 55,
  parameter int T_AA    = 55,
  parameter int T_DOE   = 25,
  parameter int T_DBE   = 25,
  parameter int T_HZ    = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [8*LANES-1:0] req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               rsp_valid,
  output logic [8*LANES-1:0] rsp_rdata,
  output logic [AW-1:0]      sram_addr,
  output logic               sram_ce_n,
  output logic               sram_we_n,
  output logic               sram_oe_n,
  output logic [LANES-1:0]   sram_be_n,
  output logic [8*LANES-1:0] sram_dq_out,
  output logic               sram_dq_oe,
  input  logic [8*LANES-1:0] sram_dq_in
);

  // Address and strobes lead the write pulse by one cycle, so that cycle counts toward their lead
  localparam int N_WE = imax(imax(ns2cyc(T_PWE, CLK_NS), ns2cyc(T_SD, CLK_NS) + 1),
                             imax(ns2cyc(T_AW, CLK_NS) - 1, ns2cyc(T_SLEAD, CLK_NS) - 1));
  localparam int N_TAIL = imax(1, ns2cyc(T_WC, CLK_NS) - 1 - N_WE);
  localparam int N_RD   = imax(imax(ns2cyc(T_RC, CLK_NS), ns2cyc(T_AA, CLK_NS)),
                               imax(ns2cyc(T_DOE, CLK_NS), ns2cyc(T_DBE, CLK_NS)));
  localparam int N_HZ   = ns2cyc(T_HZ, CLK_NS);
  localparam int N_MAX  = imax(imax(N_WE, N_TAIL), imax(N_RD, N_HZ));
  localparam int CW     = $clog2(N_MAX + 1);

  logic          accept, noop_rd, cap;
  logic          cnt_zero, cnt_load;
  logic [CW-1:0] cnt_val;

  sram_ctl_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  sram_ctl_seq #(
    .LANES (LANES),
    .CW    (CW),
    .N_WE  (N_WE),
    .N_TAIL(N_TAIL),
    .N_RD  (N_RD),
    .N_HZ  (N_HZ)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_be   (req_be),
    .req_ready(req_ready),
    .accept   (accept),
    .noop_rd  (noop_rd),
    .cap      (cap),
    .cnt_zero (cnt_zero),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .be_n     (sram_be_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_ctl_dpath #(.AW(AW), .LANES(LANES)) i_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .cap       (cap),
    .noop_rd   (noop_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .sram_dq_in(sram_dq_in),
    .addr_q    (sram_addr),
    .wdata_q   (sram_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [7:0]  req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [7:0]  sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_out, sram_dq_in;

  always #2.5 clk = ~clk;

  sram_ctl #(.AW(AW)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Separate counters per process
  int d_checks = 0, d_fails = 0;
  int m_checks = 0, m_fails = 0;
  int s_checks = 0, s_fails = 0;

  task automatic chk_d(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    d_checks++;
    if (!ok) begin d_fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask
  task automatic chk_m(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    m_checks++;
    if (!ok) begin m_fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask
  task automatic chk_s(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    s_checks++;
    if (!ok) begin s_fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  // Memory model
  logic [15:0] mem    [0:255];
  logic [15:0] shadow [0:255];
  int          age, wl, dcnt, hz;
  logic [7:0]  age_addr, lat_a;
  logic [15:0] lat_d;
  logic [1:0]  lat_be;
  logic        rd_act;

  assign rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (rd_act && age >= 11 && !sram_be_n[l]) sram_dq_in[l*8 +: 8] = mem[sram_addr][l*8 +: 8];
      else                                       sram_dq_in[l*8 +: 8] = 8'hA5;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_act) begin
        if (age > 0 && sram_addr == age_addr) age <= age + 1;
        else age <= 1;
        age_addr <= sram_addr;
      end else begin
        age <= 0;
      end
      if (sram_dq_oe) chk_m(sram_oe_n && hz >= 4, "R7 drive inside turn-off window", hz, 4);
      if (!sram_oe_n) hz <= 0;
      else if (hz < 1000) hz <= hz + 1;
      if (!sram_we_n && !sram_ce_n) begin
        wl     <= wl + 1;
        lat_a  <= sram_addr;
        lat_be <= ~sram_be_n;
        if (sram_dq_oe) begin dcnt <= dcnt + 1; lat_d <= sram_dq_out; end
      end else if (wl > 0) begin
        chk_m(wl >= 8, "R1 write pulse width", wl, 8);
        chk_m(dcnt >= 5, "R3 data setup before write end", dcnt, 5);
        for (int l = 0; l < 2; l++)
          if (lat_be[l]) mem[lat_a][l*8 +: 8] <= lat_d[l*8 +: 8];
        wl   <= 0;
        dcnt <= 0;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic [15:0] d;
    int          c;
    string       tag;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        chk_s(1'b0, "R5 unexpected response", rsp_rdata, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk_s(rsp_rdata == e.d, e.tag, rsp_rdata, e.d);
        chk_s(cyc == e.c, "R5 response cycle", cyc, e.c);
      end
    end
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic issue(input bit wr, input logic [7:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    int   j, wlow;
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (!wr) begin
      e.tag = tag;
      if (be == 2'b00) begin e.d = '0; e.c = cyc + 1; end
      else begin e.d = shadow[a] & lane_mask(be); e.c = cyc + 1 + 11; end
      q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (be == 2'b00) begin
      chk_d(sram_ce_n == 1'b1, "R8 no-op keeps chip enable high", sram_ce_n, 1);
      chk_d(req_ready == 1'b1, "R8 no-op keeps ready high", req_ready, 1);
    end else if (wr) begin
      chk_d(!sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && sram_be_n == ~be && sram_addr == a,
            "R2 address/strobe lead", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, sram_be_n}, {4'b0110, ~be});
      @(negedge clk);
      chk_d(!sram_we_n && !sram_dq_oe, "R3 no drive in first WE cycle", {sram_we_n, sram_dq_oe}, 2'b00);
      @(negedge clk);
      chk_d(!sram_we_n && sram_dq_oe && sram_oe_n && sram_dq_out == d, "R3 drive with OE high",
            sram_dq_out, d);
      wlow = 2;
      for (j = 3; j < 60; j++) begin
        @(negedge clk);
        if (!sram_we_n) wlow++;
        if (req_ready) break;
      end
      chk_d(j == 11, "R4 write cycle length", j, 11);
      chk_d(wlow == 8, "R1 write pulse cycles", wlow, 8);
      for (int l = 0; l < 2; l++)
        if (be[l]) shadow[a][l*8 +: 8] = d[l*8 +: 8];
    end else begin
      chk_d(!sram_ce_n && !sram_oe_n && sram_we_n && sram_be_n == ~be && sram_addr == a,
            "R5 read strobes", {sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, {3'b001, ~be});
      for (j = 1; j < 60; j++) begin
        @(negedge clk);
        if (j == 11) chk_d(sram_ce_n && sram_oe_n && sram_be_n == 2'b11, "R7 strobes released",
                           {sram_ce_n, sram_oe_n, sram_be_n}, 4'hF);
        if (req_ready) break;
      end
      chk_d(j == 15, "R7 read plus recovery length", j, 15);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             d_checks + m_checks + s_checks + 1, d_fails + m_fails + s_fails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    age = 0; wl = 0; dcnt = 0; hz = 1000; age_addr = '0; lat_a = '0; lat_d = '0; lat_be = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_d(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
    chk_d(rsp_valid == 1'b0, "R10 no response in reset", rsp_valid, 0);
    chk_d({sram_ce_n, sram_we_n, sram_oe_n, sram_be_n} == 5'h1F, "R10 strobes high",
          {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n}, 5'h1F);
    chk_d(sram_dq_oe == 1'b0, "R10 drive off", sram_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_d(req_ready && !rsp_valid && sram_ce_n && !sram_dq_oe, "R10 state after release",
          {req_ready, rsp_valid, sram_ce_n, sram_dq_oe}, 4'b1010);

    issue(1'b1, 8'h03, 16'h1234, 2'b11, "R2 full write");
    issue(1'b0, 8'h03, 16'h0000, 2'b11, "R5 full read");
    issue(1'b1, 8'h03, 16'hABCD, 2'b01, "R2 low lane write");
    issue(1'b0, 8'h03, 16'h0000, 2'b11, "R5 read after low lane write");
    issue(1'b1, 8'h03, 16'h5F77, 2'b10, "R2 high lane write");
    issue(1'b0, 8'h03, 16'h0000, 2'b10, "R6 high lane read, low lane zero");
    issue(1'b0, 8'h03, 16'h0000, 2'b01, "R6 low lane read, high lane zero");
    issue(1'b1, 8'h03, 16'hFFFF, 2'b00, "R8 no-op write");
    issue(1'b0, 8'h03, 16'h0000, 2'b11, "R8 word unchanged by no-op write");
    issue(1'b0, 8'h03, 16'h0000, 2'b00, "R8 no-op read returns zero");
    // Read followed at once by write: turnaround (R7)
    for (int k = 0; k < 6; k++) begin
      issue(1'b0, 8'h03, 16'h0000, 2'b11, "R5 read before turnaround");
      issue(1'b1, 8'(8'h40 + k * 37), 16'h0F1E ^ 16'(k * 16'h1111), 2'b11, "R7 write after read");
    end
    for (int k = 0; k < 6; k++)
      issue(1'b0, 8'(8'h40 + k * 37), 16'h0000, 2'b11, "R5 pattern readback");
    issue(1'b1, 8'hFF, 16'h8001, 2'b11, "R2 top address write");
    issue(1'b0, 8'hFF, 16'h0000, 2'b11, "R5 top address read");

    repeat (20) @(negedge clk);
    chk_d(q.size() == 0, "R5 all responses returned", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             d_checks + m_checks + s_checks, d_fails + m_fails + s_fails);
    $finish;
  end

endmodule